// File: doc/BRIEF.md
# Effective Address Sequencer

This block sits between the instruction decoder and the execute stage of a CPU with 16-bit accumulator and index registers and 24-bit addresses. When it is started, it takes an addressing-mode code. It fetches the operand bytes that follow the opcode and then performs any pointer reads the mode calls for. At the end it hands back either a 24-bit effective address or an immediate operand value.

All memory traffic goes through one byte-wide read port with a request/ready handshake. That traffic covers operand bytes, pointer bytes, and the dummy read of the register-only modes. The register values, bank bytes, width flags and program counter are sampled on the start cycle.

The caller sees a one-cycle completion strobe. It also sees a registered result, a flag telling whether that result is a value or an address, and the program counter advanced past the operand bytes.

Top module: `eag_seq`

## Requirements
- R1: Mode code 0 is an immediate that is always one byte wide. It fetches one operand byte, and the result is that byte zero-extended.
- R2: Mode code 1 is an immediate sized by `idx8`. It fetches one byte when `idx8` is 1 and two bytes otherwise. Two bytes are assembled little-endian into result bits 15:0.
- R3: Mode code 2 is an immediate sized by `mem8`. It fetches one byte when `mem8` is 1 and two bytes otherwise. Two bytes are assembled little-endian into result bits 15:0.
- R4: These are the mode codes:
  - 0/1/2: immediates
  - 3: absolute; 4: absolute+X; 5: absolute+Y
  - 6: long; 7: long+X
  - 8: direct; 9: direct+X; 10: direct+Y
  - 11: direct indirect; 12: direct X-indexed indirect; 13: direct indirect +Y
  - 14: direct indirect long; 15: direct indirect long +Y
  - 16: stack relative; 17: stack relative indirect +Y
  - 18: accumulator; 19: implied; 20: stack
  - 21: short relative; 22: long relative
  - 23: absolute indexed indirect

  `is_imm` is 1 with the result exactly when the mode code is at most 2.
- R5: The absolute family uses the operand bytes as follows:
  - Absolute gives `{data_bank, word}`. Its X and Y forms add the index to that 24-bit value, with carry into the bank.
  - Long takes a 3-byte little-endian operand as the address. Its X form adds X.
- R6: Direct modes give `reg_dp + byte (+X or +Y)`, truncated to 16 bits, in bank 0. The X-indexed indirect mode reads pointer bytes at bank 0 offsets `reg_dp+byte+X` and `+1` (16-bit wrap) and returns `{data_bank, pointer}`.
- R7: Direct indirect reads a 16-bit pointer at `reg_dp+byte` and `+1`, returns `{data_bank, pointer}`, and the Y form adds Y. Direct indirect long reads three bytes there into a 24-bit address, and its Y form adds Y.
- R8: Stack relative returns `(byte + reg_sp)` truncated to 16 bits. Its indirect form returns `{data_bank, that}` plus Y.
- R9: The register-only modes behave as follows:
  - Accumulator and implied make one read at `{prog_bank, pc}` without advancing the PC, and return 0.
  - Stack returns `reg_sp`.
  - Short relative returns the operand byte, and long relative returns the operand word.
- R10: Absolute indexed indirect reads a little-endian word at `{prog_bank, operand word}` and `+1`, and returns that word.
- R11: Operand byte i is read at `{prog_bank, pc_in+i}` with 16-bit wrap, and `pc_out` advances by one per operand byte accepted. A request whose `mem_ready` is low holds its address to the next cycle.
- R12: `done` is high for exactly one cycle, and `result`/`is_imm` change only together with it and hold until the next `done`. A `start` while a mode is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new address computation (idle only) |
| mode | input | 5 | Addressing-mode code |
| idx8 | input | 1 | Index registers are 8 bits wide |
| mem8 | input | 1 | Accumulator/memory is 8 bits wide |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_dp | input | 16 | Direct-page base |
| prog_bank | input | 8 | Program bank |
| data_bank | input | 8 | Data bank |
| pc_in | input | 16 | Address of the first operand byte |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Read address |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read completes this cycle |
| done | output | 1 | One-cycle completion strobe |
| result | output | 24 | Effective address or immediate value |
| is_imm | output | 1 | Result is an immediate value |
| pc_out | output | 16 | Program counter past the operand bytes |

## Verification
Two events can share a cycle: the completion strobe of one computation and the start pulse of the next. The bench provokes this by issuing every new start in the very cycle it first sees `done` high. It then judges that the finished result was sampled before the start took effect, that the result stayed put until the next strobe, and that the new computation still fetched the right bytes. A second pairing, a start pulse landing during a pointer read, is driven directly; the check is that the access count and result belong to the first mode only.

// File: rtl/eag_pkg.sv
package eag_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [4:0] {
      EA_IMM8       = 5'd0,
      EA_IMMX       = 5'd1,
      EA_IMMM       = 5'd2,
      EA_ABS        = 5'd3,
      EA_ABS_X      = 5'd4,
      EA_ABS_Y      = 5'd5,
      EA_LONG       = 5'd6,
      EA_LONG_X     = 5'd7,
      EA_DIR        = 5'd8,
      EA_DIR_X      = 5'd9,
      EA_DIR_Y      = 5'd10,
      EA_DIR_IND    = 5'd11,
      EA_DIR_X_IND  = 5'd12,
      EA_DIR_IND_Y  = 5'd13,
      EA_DIR_LIND   = 5'd14,
      EA_DIR_LIND_Y = 5'd15,
      EA_SREL       = 5'd16,
      EA_SREL_IND_Y = 5'd17,
      EA_ACC        = 5'd18,
      EA_IMP        = 5'd19,
      EA_STK        = 5'd20,
      EA_REL        = 5'd21,
      EA_REL_L      = 5'd22,
      EA_ABS_X_IND  = 5'd23
   } ea_mode_e;

   // immediate kinds occupy the lowest codes so one compare classifies them
   localparam logic [4:0] EA_LAST_IMM = EA_IMMM;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_OPND, SQ_PTR, SQ_DUMMY, SQ_FIN
   } sq_state_e;

   typedef enum logic [1:0] {
      PB_DIRECT, PB_DIRECT_X, PB_PROG
   } ptr_base_e;

   typedef struct packed {
      logic [1:0] n_opnd;
      logic [1:0] n_ptr;
      ptr_base_e  base;
      logic       dummy;
   } ea_plan_t;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
   import eag_pkg::*;
#(
   parameter bit DUMMY_EN = 1'b1
) (
   input  logic [4:0] mode,
   input  logic       idx8,
   input  logic       mem8,
   output ea_plan_t   plan
);
   logic dummy_sel;
   logic is_reg_only;

   assign is_reg_only = (mode == EA_ACC) || (mode == EA_IMP);

   generate
      if (DUMMY_EN) begin : g_dummy
         assign dummy_sel = is_reg_only;
      end else begin : g_no_dummy
         assign dummy_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      plan.n_opnd = 2'd0;
      plan.n_ptr  = 2'd0;
      plan.base   = PB_DIRECT;
      plan.dummy  = dummy_sel;
      case (mode)
         EA_IMM8:  plan.n_opnd = 2'd1;
         EA_IMMX:  plan.n_opnd = idx8 ? 2'd1 : 2'd2;
         EA_IMMM:  plan.n_opnd = mem8 ? 2'd1 : 2'd2;
         EA_ABS, EA_ABS_X, EA_ABS_Y, EA_REL_L:
                   plan.n_opnd = 2'd2;
         EA_LONG, EA_LONG_X:
                   plan.n_opnd = 2'd3;
         EA_DIR, EA_DIR_X, EA_DIR_Y, EA_SREL, EA_SREL_IND_Y, EA_REL:
                   plan.n_opnd = 2'd1;
         EA_DIR_IND, EA_DIR_IND_Y: begin
            plan.n_opnd = 2'd1;
            plan.n_ptr  = 2'd2;
         end
         EA_DIR_X_IND: begin
            plan.n_opnd = 2'd1;
            plan.n_ptr  = 2'd2;
            plan.base   = PB_DIRECT_X;
         end
         EA_DIR_LIND, EA_DIR_LIND_Y: begin
            plan.n_opnd = 2'd1;
            plan.n_ptr  = 2'd3;
         end
         EA_ABS_X_IND: begin
            plan.n_opnd = 2'd2;
            plan.n_ptr  = 2'd2;
            plan.base   = PB_PROG;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/eag_addr_gen.sv
module eag_addr_gen
   import eag_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int OFS_W  = 16,
   localparam int ADDR_W = BANK_W + OFS_W
) (
   input  sq_state_e         state,
   input  logic [1:0]        idx,
   input  ptr_base_e         base,
   input  logic [OFS_W-1:0]  pc,
   input  logic [BANK_W-1:0] pbank,
   input  logic [OFS_W-1:0]  dp,
   input  logic [OFS_W-1:0]  xr,
   input  logic [OFS_W-1:0]  opnd_word,
   output logic [ADDR_W-1:0] addr
);
   logic [OFS_W-1:0] step;
   logic [OFS_W-1:0] dir_ofs;
   logic [OFS_W-1:0] ptr_ofs;

   assign step    = OFS_W'(idx);
   assign dir_ofs = dp + OFS_W'(opnd_word[BYTE_W-1:0]);

   always_comb begin
      case (base)
         PB_DIRECT_X: ptr_ofs = dir_ofs + xr + step;
         PB_PROG:     ptr_ofs = opnd_word + step;
         default:     ptr_ofs = dir_ofs + step;
      endcase
   end

   always_comb begin
      case (state)
         SQ_OPND, SQ_DUMMY: addr = {pbank, pc};
         SQ_PTR: addr = (base == PB_PROG) ? {pbank, ptr_ofs}
                                          : {{BANK_W{1'b0}}, ptr_ofs};
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/eag_combine.sv
module eag_combine
   import eag_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int OFS_W  = 16,
   localparam int ADDR_W = BANK_W + OFS_W
) (
   input  logic [4:0]        mode,
   input  logic [ADDR_W-1:0] opnd,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [OFS_W-1:0]  xr,
   input  logic [OFS_W-1:0]  yr,
   input  logic [OFS_W-1:0]  sp,
   input  logic [OFS_W-1:0]  dp,
   input  logic [BANK_W-1:0] dbank,
   output logic [ADDR_W-1:0] ea
);
   localparam logic [BANK_W-1:0] ZB = '0;

   logic [OFS_W-1:0]  word;
   logic [OFS_W-1:0]  dir_ofs;
   logic [OFS_W-1:0]  srel_ofs;
   logic [ADDR_W-1:0] x24, y24;

   assign word     = opnd[OFS_W-1:0];
   assign dir_ofs  = dp + OFS_W'(opnd[BYTE_W-1:0]);
   assign srel_ofs = sp + OFS_W'(opnd[BYTE_W-1:0]);
   assign x24      = {ZB, xr};
   assign y24      = {ZB, yr};

   always_comb begin
      case (mode)
         EA_IMM8, EA_IMMX, EA_IMMM, EA_REL, EA_REL_L:
                          ea = {ZB, word};
         EA_ABS:          ea = {dbank, word};
         EA_ABS_X:        ea = {dbank, word} + x24;
         EA_ABS_Y:        ea = {dbank, word} + y24;
         EA_LONG:         ea = opnd;
         EA_LONG_X:       ea = opnd + x24;
         EA_DIR:          ea = {ZB, dir_ofs};
         EA_DIR_X:        ea = {ZB, dir_ofs + xr};
         EA_DIR_Y:        ea = {ZB, dir_ofs + yr};
         EA_DIR_IND, EA_DIR_X_IND:
                          ea = {dbank, ptr[OFS_W-1:0]};
         EA_DIR_IND_Y:    ea = {dbank, ptr[OFS_W-1:0]} + y24;
         EA_DIR_LIND:     ea = ptr;
         EA_DIR_LIND_Y:   ea = ptr + y24;
         EA_SREL:         ea = {ZB, srel_ofs};
         EA_SREL_IND_Y:   ea = {dbank, srel_ofs} + y24;
         EA_STK:          ea = {ZB, sp};
         EA_ABS_X_IND:    ea = {ZB, ptr[OFS_W-1:0]};
         default:         ea = '0;
      endcase
   end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
   import eag_pkg::*;
#(
   parameter int BANK_W   = 8,
   parameter int OFS_W    = 16,
   parameter bit DUMMY_EN = 1'b1,
   localparam int ADDR_W  = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [4:0]        mode,
   input  logic              idx8,
   input  logic              mem8,
   input  logic [OFS_W-1:0]  reg_x,
   input  logic [OFS_W-1:0]  reg_y,
   input  logic [OFS_W-1:0]  reg_sp,
   input  logic [OFS_W-1:0]  reg_dp,
   input  logic [BANK_W-1:0] prog_bank,
   input  logic [BANK_W-1:0] data_bank,
   input  logic [OFS_W-1:0]  pc_in,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done,
   output logic [ADDR_W-1:0] result,
   output logic              is_imm,
   output logic [OFS_W-1:0]  pc_out
);
   localparam int NBYTES = ADDR_W / BYTE_W;

   generate
      if (BANK_W != BYTE_W || OFS_W != 2 * BYTE_W) begin : g_bad_geom
         $error("eag_seq: bank must be one byte and offset two bytes");
      end
   endgenerate

   sq_state_e         state_q;
   logic [1:0]        idx_q;
   logic [4:0]        mode_q;
   ea_plan_t          plan_d, plan_q;
   logic [OFS_W-1:0]  x_q, y_q, sp_q, dp_q, pc_q;
   logic [BANK_W-1:0] pb_q, db_q;
   logic [ADDR_W-1:0] opnd_q, ptr_q;
   logic [ADDR_W-1:0] ea_w;
   logic [ADDR_W-1:0] result_q;
   logic              done_q, is_imm_q;
   logic              accept, last_byte;

   eag_decode #(.DUMMY_EN(DUMMY_EN)) u_dec (
      .mode (mode),
      .idx8 (idx8),
      .mem8 (mem8),
      .plan (plan_d)
   );

   eag_addr_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_agen (
      .state     (state_q),
      .idx       (idx_q),
      .base      (plan_q.base),
      .pc        (pc_q),
      .pbank     (pb_q),
      .dp        (dp_q),
      .xr        (x_q),
      .opnd_word (opnd_q[OFS_W-1:0]),
      .addr      (mem_addr)
   );

   eag_combine #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_comb (
      .mode  (mode_q),
      .opnd  (opnd_q),
      .ptr   (ptr_q),
      .xr    (x_q),
      .yr    (y_q),
      .sp    (sp_q),
      .dp    (dp_q),
      .dbank (db_q),
      .ea    (ea_w)
   );

   assign mem_req = (state_q == SQ_OPND) || (state_q == SQ_PTR) ||
                    (state_q == SQ_DUMMY);
   assign accept  = mem_req && mem_ready;

   always_comb begin
      case (state_q)
         SQ_OPND: last_byte = (idx_q == plan_q.n_opnd - 2'd1);
         SQ_PTR:  last_byte = (idx_q == plan_q.n_ptr - 2'd1);
         default: last_byte = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         idx_q    <= '0;
         mode_q   <= '0;
         plan_q   <= '0;
         x_q      <= '0;
         y_q      <= '0;
         sp_q     <= '0;
         dp_q     <= '0;
         pc_q     <= '0;
         pb_q     <= '0;
         db_q     <= '0;
         opnd_q   <= '0;
         ptr_q    <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
         is_imm_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  mode_q <= mode;
                  plan_q <= plan_d;
                  x_q    <= reg_x;
                  y_q    <= reg_y;
                  sp_q   <= reg_sp;
                  dp_q   <= reg_dp;
                  pc_q   <= pc_in;
                  pb_q   <= prog_bank;
                  db_q   <= data_bank;
                  opnd_q <= '0;
                  ptr_q  <= '0;
                  idx_q  <= '0;
                  if (plan_d.n_opnd != 2'd0) state_q <= SQ_OPND;
                  else if (plan_d.dummy)     state_q <= SQ_DUMMY;
                  else                       state_q <= SQ_FIN;
               end
            end
            SQ_OPND: begin
               if (accept) begin
                  for (int i = 0; i < NBYTES; i++) begin
                     if (idx_q == 2'(i)) opnd_q[i*BYTE_W +: BYTE_W] <= mem_rdata;
                  end
                  pc_q <= pc_q + OFS_W'(1);
                  if (last_byte) begin
                     idx_q   <= '0;
                     state_q <= (plan_q.n_ptr != 2'd0) ? SQ_PTR : SQ_FIN;
                  end else begin
                     idx_q <= idx_q + 2'd1;
                  end
               end
            end
            SQ_PTR: begin
               if (accept) begin
                  for (int i = 0; i < NBYTES; i++) begin
                     if (idx_q == 2'(i)) ptr_q[i*BYTE_W +: BYTE_W] <= mem_rdata;
                  end
                  if (last_byte) begin
                     idx_q   <= '0;
                     state_q <= SQ_FIN;
                  end else begin
                     idx_q <= idx_q + 2'd1;
                  end
               end
            end
            SQ_DUMMY: begin
               if (accept) state_q <= SQ_FIN;
            end
            SQ_FIN: begin
               result_q <= ea_w;
               is_imm_q <= (mode_q <= EA_LAST_IMM);
               done_q   <= 1'b1;
               state_q  <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign done   = done_q;
   assign result = result_q;
   assign is_imm = is_imm_q;
   assign pc_out = pc_q;
endmodule

// File: rtl/eag_seq_chk.sv
module eag_seq_chk #(
   parameter int AW = 24,
   parameter int OW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          mem_req,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic [AW-1:0] result,
   input logic          is_imm,
   input logic [OW-1:0] pc_out
);
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   a_r12_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   a_r4_imm_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_imm) |-> (result[AW-1:OW] == '0));

   a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(pc_out) && !$past(start)) |->
         ($past(mem_req && mem_ready) && pc_out == OW'($past(pc_out) + OW'(1))));
endmodule

bind eag_seq eag_seq_chk #(.AW(24), .OW(16)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mem_req   (mem_req),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .done      (done),
   .result    (result),
   .is_imm    (is_imm),
   .pc_out    (pc_out)
);

// File: tb/eag_seq_tb.sv
`timescale 1ns/1ps
module eag_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  mode = '0;
   logic        idx8 = 1'b0, mem8 = 1'b0;
   logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_dp = '0, pc_in = '0;
   logic [7:0]  prog_bank = '0, data_bank = '0;
   logic        mem_req, mem_ready = 1'b1, done, is_imm;
   logic [23:0] mem_addr, result;
   logic [7:0]  mem_rdata;
   logic [15:0] pc_out;

   int n_chk = 0, n_bad = 0;
   int acc_cnt = 0;
   logic [23:0] last_addr = '0;
   bit ready_rand = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   eag_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx8(idx8), .mem8(mem8),
      .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_dp(reg_dp),
      .prog_bank(prog_bank), .data_bank(data_bank), .pc_in(pc_in),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .done(done), .result(result), .is_imm(is_imm), .pc_out(pc_out)
   );

   function automatic logic [7:0] mb(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ (a[23:16] * 8'd3) ^ 8'hA5;
   endfunction

   assign mem_rdata = mb(mem_addr);

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ready) begin
         acc_cnt   <= acc_cnt + 1;
         last_addr <= mem_addr;
      end
   end

   always @(negedge clk) mem_ready <= ready_rand ? (($urandom % 4) != 0) : 1'b1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dbyte(input logic [15:0] base, input int j);
      return mb({8'h00, 16'(base + 16'(j))});
   endfunction

   function automatic logic [23:0] exp_ea(input logic [4:0] md);
      logic [7:0] b0, b1, b2;
      logic [15:0] w, db, dx, sr;
      logic [23:0] l;
      b0 = mb({prog_bank, pc_in});
      b1 = mb({prog_bank, 16'(pc_in + 16'd1)});
      b2 = mb({prog_bank, 16'(pc_in + 16'd2)});
      w  = {b1, b0};
      l  = {b2, b1, b0};
      db = reg_dp + {8'h00, b0};
      dx = db + reg_x;
      sr = reg_sp + {8'h00, b0};
      case (md)
         5'd0:  return {16'h0, b0};
         5'd1:  return idx8 ? {16'h0, b0} : {8'h0, w};
         5'd2:  return mem8 ? {16'h0, b0} : {8'h0, w};
         5'd3:  return {data_bank, w};
         5'd4:  return {data_bank, w} + {8'h0, reg_x};
         5'd5:  return {data_bank, w} + {8'h0, reg_y};
         5'd6:  return l;
         5'd7:  return l + {8'h0, reg_x};
         5'd8:  return {8'h0, db};
         5'd9:  return {8'h0, 16'(db + reg_x)};
         5'd10: return {8'h0, 16'(db + reg_y)};
         5'd11: return {data_bank, dbyte(db, 1), dbyte(db, 0)};
         5'd12: return {data_bank, dbyte(dx, 1), dbyte(dx, 0)};
         5'd13: return {data_bank, dbyte(db, 1), dbyte(db, 0)} + {8'h0, reg_y};
         5'd14: return {dbyte(db, 2), dbyte(db, 1), dbyte(db, 0)};
         5'd15: return {dbyte(db, 2), dbyte(db, 1), dbyte(db, 0)} + {8'h0, reg_y};
         5'd16: return {8'h0, sr};
         5'd17: return {data_bank, sr} + {8'h0, reg_y};
         5'd20: return {8'h0, reg_sp};
         5'd21: return {16'h0, b0};
         5'd22: return {8'h0, w};
         5'd23: return {8'h0, mb({prog_bank, 16'(w + 16'd1)}), mb({prog_bank, w})};
         default: return 24'h0;
      endcase
   endfunction

   function automatic int exp_nop(input logic [4:0] md);
      case (md)
         5'd0, 5'd21: return 1;
         5'd1: return idx8 ? 1 : 2;
         5'd2: return mem8 ? 1 : 2;
         5'd3, 5'd4, 5'd5, 5'd22, 5'd23: return 2;
         5'd6, 5'd7: return 3;
         5'd18, 5'd19, 5'd20: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_nacc(input logic [4:0] md);
      int n;
      n = exp_nop(md);
      if (md == 5'd11 || md == 5'd12 || md == 5'd13 || md == 5'd23) n += 2;
      if (md == 5'd14 || md == 5'd15) n += 3;
      if (md == 5'd18 || md == 5'd19) n += 1;
      return n;
   endfunction

   function automatic string req_of(input logic [4:0] md);
      if (md == 5'd0) return "R1";
      if (md == 5'd1) return "R2";
      if (md == 5'd2) return "R3";
      if (md <= 5'd7) return "R5";
      if (md <= 5'd12) return "R6";
      if (md <= 5'd15) return "R7";
      if (md <= 5'd17) return "R8";
      if (md <= 5'd22) return "R9";
      return "R10";
   endfunction

   // starts at a negedge; returns at the negedge where done is first seen high
   task automatic do_op(input logic [4:0] md);
      logic [23:0] prev, e;
      logic [15:0] pc0;
      int base, n;
      bit hold_ok;
      e    = exp_ea(md);
      pc0  = pc_in;
      base = acc_cnt;
      prev = result;
      mode = md;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      hold_ok = 1'b1;
      n = 0;
      while (!done && n < 400) begin
         if (result !== prev) hold_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      chk(n < 400, "R12 timeout", 32'(n), 32'd400);
      chk(hold_ok, "R12 result hold", {8'h0, result}, {8'h0, prev});
      chk(result == e, req_of(md), {8'h0, result}, {8'h0, e});
      chk(is_imm == (md <= 5'd2), "R4 is_imm", {31'h0, is_imm}, {31'h0, md <= 5'd2});
      chk(pc_out == 16'(pc0 + 16'(exp_nop(md))), "R11 pc_out", {16'h0, pc_out},
          {16'h0, 16'(pc0 + 16'(exp_nop(md)))});
      chk(acc_cnt - base == exp_nacc(md), "R11 access count", 32'(acc_cnt - base),
          32'(exp_nacc(md)));
      if (md == 5'd18 || md == 5'd19)
         chk(last_addr == {prog_bank, pc0}, "R9 dummy address", {8'h0, last_addr},
             {8'h0, prog_bank, pc0});
   endtask

   task automatic rand_regs();
      reg_x = 16'($urandom); reg_y = 16'($urandom);
      reg_sp = 16'($urandom); reg_dp = 16'($urandom);
      prog_bank = 8'($urandom); data_bank = 8'($urandom);
      pc_in = (($urandom % 8) == 0) ? 16'hFFFE : 16'($urandom);
      idx8 = 1'($urandom); mem8 = 1'($urandom);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [23:0] e;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req && result == 24'h0 && !is_imm, "R12 reset state",
          {7'h0, done, mem_req, result[22:0]}, 32'h0);

      // directed: width flags on the sized immediates
      reg_x = 16'h1234; prog_bank = 8'h12; pc_in = 16'h4000;
      idx8 = 1'b1; mem8 = 1'b0; do_op(5'd1); do_op(5'd2); do_op(5'd0);
      idx8 = 1'b0; mem8 = 1'b1; do_op(5'd1); do_op(5'd2);
      // directed: bank carry, wraps, truncations
      data_bank = 8'h7F; reg_x = 16'hFFFF; pc_in = 16'h0100; do_op(5'd4);
      pc_in = 16'hFFFF; do_op(5'd6);
      reg_dp = 16'hFFFF; reg_x = 16'h0001; do_op(5'd12); do_op(5'd9);
      reg_sp = 16'hFFF0; do_op(5'd16); reg_y = 16'hFFFF; do_op(5'd17);
      do_op(5'd18); do_op(5'd19); do_op(5'd20); do_op(5'd23); do_op(5'd15);

      // directed: start while a pointer read is in progress (R12)
      reg_dp = 16'h0200; reg_y = 16'h0010; pc_in = 16'h8000; prog_bank = 8'h03;
      @(negedge clk);
      e = exp_ea(5'd15);
      begin
         int base, n;
         base = acc_cnt;
         mode = 5'd15; start = 1'b1;
         @(negedge clk); start = 1'b0;
         @(negedge clk); mode = 5'd0; start = 1'b1;
         @(negedge clk); start = 1'b0;
         n = 0;
         while (!done && n < 400) begin @(negedge clk); n++; end
         chk(result == e, "R12 busy start ignored", {8'h0, result}, {8'h0, e});
         chk(acc_cnt - base == 4, "R12 busy start accesses", 32'(acc_cnt - base), 32'd4);
      end

      // random, back-to-back: each start lands in the done cycle
      ready_rand = 1'b1;
      for (int k = 0; k < 400; k++) begin
         rand_regs();
         do_op(5'($urandom_range(0, 23)));
      end
      ready_rand = 1'b0;
      @(negedge clk);
      summary();
   end
endmodule